// File: doc/BRIEF.md
# CAN Receive-Buffer Packetizing Reader

This block pulls whole receive message buffers out of a CAN controller's message memory and joins a configurable number of them into one outgoing packet. Each buffer starts with an 8-byte message header, and its configured size counts that header. The block clamps the configured size to a legal window. It keeps the header of the first buffer in a packet and skips the header of every later buffer in the same packet. It alternates between two receive buffers, a ping-pong pair.

Each trigger pulse announces one more filled buffer. Triggers are counted, so a burst of them is served in order. For each buffer the block issues 32-bit word reads at byte offsets into the message memory. The memory returns each word one cycle after the request. The block then forwards the words as a packed stream marked with start-of-packet and end-of-packet. When a buffer's length is not a multiple of four, the last word carries a partial byte-valid mask. Status outputs report the zero-based buffer index within the packet, the next read offset and the ping-pong buffer in use.

Top module: `can_rxbuf_packer`

## Requirements
- R1: A configured buffer size below 16 bytes is read as exactly 16 bytes.
- R2: A configured buffer size above 72 bytes is read as exactly 72 bytes.
- R3: With a configured buffer count N of one or more, N buffers form one packet. The end-of-packet flag is set only on the last word of the N-th buffer.
- R4: The first buffer of a packet is read from byte offset 0. Every later buffer in the same packet is read from offset 8, which skips its header.
- R5: The start-of-packet flag is set on the first output word of each packet and on no other word.
- R6: A configured buffer count of zero behaves as a count of one, so every buffer closes its own packet.
- R7: Reads are 4-byte words at offsets that are multiples of 4. Bit j of the byte mask is set when byte j, at data bits 8j+7..8j, is valid. The last word of a buffer whose size is not a multiple of 4 has only its lower (size mod 4) bits set. Bytes that are not valid are output as zero.
- R8: The ping-pong select starts at 0 after reset, selects the buffer being read and toggles once for each buffer completed.
- R9: When the block is idle, the status index is the zero-based position of the next buffer within its packet, and the status offset is the offset that buffer will be read from.
- R10: After reset, no read request and no output word are issued, and the status index, offset and select are all zero.
- R11: Each trigger pulse causes exactly one buffer to be read. Triggers that arrive while a buffer is being read wait their turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_buf_size | input | SIZE_W | Configured buffer size in bytes, header included |
| cfg_buf_count | input | CNT_W | Buffers per packet (0 is read as 1) |
| buf_trig | input | 1 | One-cycle pulse: one more buffer is ready |
| rd_req | output | 1 | Read request to message memory |
| rd_buf_sel | output | 1 | Ping-pong buffer addressed by the read |
| rd_offset | output | OFF_W | Byte offset of the read word |
| rd_data | input | 32 | Word returned one cycle after rd_req |
| out_valid | output | 1 | Output word valid |
| out_data | output | 32 | Output word, invalid bytes zero |
| out_bmask | output | 4 | Byte-valid mask of the output word |
| out_sop | output | 1 | First word of a packet |
| out_eop | output | 1 | Last word of a packet |
| stat_buf_idx | output | CNT_W | Zero-based buffer index within the packet |
| stat_next_off | output | OFF_W | Next read offset |
| stat_pingpong | output | 1 | Ping-pong buffer in use |

## Verification
The bench builds the block with its default parameters: 12-bit size and count fields and a 4-bit trigger counter. The 12-bit size field lets the stimulus drive sizes far outside the 16 to 72 byte window on both sides. It also covers every trailing byte count from 0 to 3. Random counts from 0 to 4 combined with bursts of up to six triggers exercise packets that close in the middle of a burst, header skips across several buffers, and the ping-pong select flipping while triggers are still waiting in the counter.

// File: rtl/crx_pkg.sv
// Package: shared constants and the per-word sideband type of the buffer reader.
// Assumes 32-bit message memory words, little-endian byte lanes.
package crx_pkg;
    localparam int BYTE_LANES = 4;
    localparam int DATA_W     = 8 * BYTE_LANES;
    localparam int HDR_BYTES  = 8;
    localparam int MIN_BYTES  = 16;
    localparam int MAX_BYTES  = 72;
    localparam int OFF_W      = $clog2(MAX_BYTES + BYTE_LANES + 1);

    typedef struct packed {
        logic                  sop;
        logic                  eop;
        logic [BYTE_LANES-1:0] mask;
    } crx_meta_t;
endpackage

// File: rtl/crx_trig_count.sv
// Module: counts outstanding buffer triggers; inc and dec in one cycle cancel.
// Assumes dec is only raised while the count is non-zero; saturates at the top.
module crx_trig_count #(
    parameter int EVT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic nz
);
    localparam logic [EVT_W-1:0] CNT_MAX = '1;

    logic [EVT_W-1:0] cnt_q;

    // Pending-trigger count update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (inc && !dec && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (dec && !inc) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign nz = (cnt_q != '0);

    // R11: a buffer is never consumed without a pending trigger.
    a_r11_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> cnt_q != '0);
endmodule

// File: rtl/crx_buf_walker.sv
// Module: walks one receive buffer at a time, issuing word reads at byte offsets.
// Tracks the buffer index in the packet, the header skip and the ping-pong select.
// Assumes a read is accepted every cycle; one idle cycle separates buffers.
module crx_buf_walker
    import crx_pkg::*;
#(
    parameter int SIZE_W = 12,
    parameter int CNT_W  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SIZE_W-1:0] cfg_size,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic             pend_nz,
    output logic             consume,
    output logic             rd_req,
    output logic             rd_sel,
    output logic [OFF_W-1:0] rd_off,
    output crx_meta_t        meta,
    output logic [CNT_W-1:0] stat_idx,
    output logic [OFF_W-1:0] stat_off,
    output logic             stat_pp
);
    localparam int OW1 = OFF_W + 1;

    logic             act_q, pp_q;
    logic [OFF_W-1:0] off_q, size_q, size_eff;
    logic [CNT_W-1:0] idx_q, cnt_q, cnt_eff, idx_nxt;
    logic             last_w, start;

    // Clamp the configured size into the legal window.
    always_comb begin
        if (cfg_size < SIZE_W'(MIN_BYTES))      size_eff = OFF_W'(MIN_BYTES);
        else if (cfg_size > SIZE_W'(MAX_BYTES)) size_eff = OFF_W'(MAX_BYTES);
        else                                    size_eff = OFF_W'(cfg_size);
    end

    // Zero buffers per packet means one.
    assign cnt_eff = (cfg_count == '0) ? CNT_W'(1) : cfg_count;

    assign start   = !act_q && pend_nz;
    assign last_w  = ({1'b0, off_q} + OW1'(BYTE_LANES)) >= {1'b0, size_q};
    assign consume = act_q && last_w;
    assign idx_nxt = (idx_q == cnt_q - 1'b1) ? '0 : idx_q + 1'b1;

    // Buffer walk: start, advance by one word, and close out at the last word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            pp_q   <= 1'b0;
            off_q  <= '0;
            size_q <= OFF_W'(MIN_BYTES);
            idx_q  <= '0;
            cnt_q  <= CNT_W'(1);
        end else if (start) begin
            act_q  <= 1'b1;
            size_q <= size_eff;
            if (idx_q == '0) cnt_q <= cnt_eff;
        end else if (act_q) begin
            if (last_w) begin
                act_q <= 1'b0;
                pp_q  <= ~pp_q;
                idx_q <= idx_nxt;
                off_q <= (idx_nxt == '0) ? '0 : OFF_W'(HDR_BYTES);
            end else begin
                off_q <= off_q + OFF_W'(BYTE_LANES);
            end
        end
    end

    // Byte lanes valid below the buffer end.
    for (genvar j = 0; j < BYTE_LANES; j++) begin : g_lane
        assign meta.mask[j] = ({1'b0, off_q} + OW1'(j)) < {1'b0, size_q};
    end

    assign meta.sop = act_q && idx_q == '0 && off_q == '0;
    assign meta.eop = act_q && last_w && idx_q == cnt_q - 1'b1;
    assign rd_req   = act_q;
    assign rd_sel   = pp_q;
    assign rd_off   = off_q;
    assign stat_idx = idx_q;
    assign stat_off = off_q;
    assign stat_pp  = pp_q;

    // R1, R2: the latched size always lies inside the window while reading.
    a_r1_size_window: assert property (@(posedge clk) disable iff (!rst_n)
        act_q |-> (size_q >= OFF_W'(MIN_BYTES) && size_q <= OFF_W'(MAX_BYTES)));
    // R4: a buffer after the first in its packet starts past the header.
    a_r4_hdr_skip: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(act_q) && idx_q != '0) |-> off_q == OFF_W'(HDR_BYTES));
    // R8: the select holds inside a buffer and flips after its last word.
    a_r8_pp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && !last_w) |=> $stable(pp_q));
    a_r8_pp_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && last_w) |=> pp_q != $past(pp_q));
    // R7: every issued mask has lane 0 set and is contiguous from the bottom.
    a_r7_mask_shape: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (meta.mask[0] && ((meta.mask + 1'b1) & meta.mask) == '0));
    // R3: the index stays below the latched count.
    a_r3_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        act_q |-> idx_q < cnt_q);
endmodule

// File: rtl/crx_out_stage.sv
// Module: aligns request sideband with the word the memory returns one cycle
// later, zeroes invalid bytes and registers the packed output.
// Assumes fixed one-cycle read latency.
module crx_out_stage
    import crx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req,
    input  crx_meta_t             meta_in,
    input  logic [DATA_W-1:0]     rd_data,
    output logic                  out_valid,
    output logic [DATA_W-1:0]     out_data,
    output logic [BYTE_LANES-1:0] out_bmask,
    output logic                  out_sop,
    output logic                  out_eop
);
    logic              v1_q;
    crx_meta_t         m1_q;
    logic [DATA_W-1:0] data_n;

    // Stage 1: hold the sideband while the memory produces the word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1_q <= 1'b0;
            m1_q <= '0;
        end else begin
            v1_q <= req;
            m1_q <= req ? meta_in : '0;
        end
    end

    // Zero bytes outside the valid mask.
    for (genvar j = 0; j < BYTE_LANES; j++) begin : g_zero
        assign data_n[8*j +: 8] = m1_q.mask[j] ? rd_data[8*j +: 8] : 8'h00;
    end

    // Stage 2: register the packed word with its flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_bmask <= '0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
        end else begin
            out_valid <= v1_q;
            out_data  <= v1_q ? data_n : '0;
            out_bmask <= m1_q.mask;
            out_sop   <= m1_q.sop;
            out_eop   <= m1_q.eop;
        end
    end

    // R5: packet marks never appear on an empty slot.
    a_r5_marks_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sop || out_eop) |-> out_valid);
endmodule

// File: rtl/can_rxbuf_packer.sv
// Module: top of the CAN receive-buffer packetizing reader. Counts triggers,
// walks buffers through message memory and packs the returned words.
// Assumes the memory returns rd_data one cycle after rd_req.
module can_rxbuf_packer
    import crx_pkg::*;
#(
    parameter int SIZE_W = 12,
    parameter int CNT_W  = 12,
    parameter int EVT_W  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SIZE_W-1:0]     cfg_buf_size,
    input  logic [CNT_W-1:0]      cfg_buf_count,
    input  logic                  buf_trig,
    output logic                  rd_req,
    output logic                  rd_buf_sel,
    output logic [OFF_W-1:0]      rd_offset,
    input  logic [DATA_W-1:0]     rd_data,
    output logic                  out_valid,
    output logic [DATA_W-1:0]     out_data,
    output logic [BYTE_LANES-1:0] out_bmask,
    output logic                  out_sop,
    output logic                  out_eop,
    output logic [CNT_W-1:0]      stat_buf_idx,
    output logic [OFF_W-1:0]      stat_next_off,
    output logic                  stat_pingpong
);
    logic      pend_nz, consume;
    crx_meta_t meta;

    crx_trig_count #(.EVT_W(EVT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc(buf_trig), .dec(consume), .nz(pend_nz)
    );

    crx_buf_walker #(.SIZE_W(SIZE_W), .CNT_W(CNT_W)) u_walk (
        .clk(clk), .rst_n(rst_n), .cfg_size(cfg_buf_size), .cfg_count(cfg_buf_count),
        .pend_nz(pend_nz), .consume(consume), .rd_req(rd_req), .rd_sel(rd_buf_sel),
        .rd_off(rd_offset), .meta(meta), .stat_idx(stat_buf_idx),
        .stat_off(stat_next_off), .stat_pp(stat_pingpong)
    );

    crx_out_stage u_out (
        .clk(clk), .rst_n(rst_n), .req(rd_req), .meta_in(meta), .rd_data(rd_data),
        .out_valid(out_valid), .out_data(out_data), .out_bmask(out_bmask),
        .out_sop(out_sop), .out_eop(out_eop)
    );
endmodule

// File: tb/tb_can_rxbuf_packer.sv
module tb_can_rxbuf_packer;
    localparam int SIZE_W = 12;
    localparam int CNT_W  = 12;
    localparam int OFF_W  = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [SIZE_W-1:0] cfg_buf_size = '0;
    logic [CNT_W-1:0]  cfg_buf_count = '0;
    logic              buf_trig = 1'b0;
    logic              rd_req, rd_buf_sel;
    logic [OFF_W-1:0]  rd_offset;
    logic [31:0]       rd_data = '0;
    logic              out_valid, out_sop, out_eop, stat_pingpong;
    logic [31:0]       out_data;
    logic [3:0]        out_bmask;
    logic [CNT_W-1:0]  stat_buf_idx;
    logic [OFF_W-1:0]  stat_next_off;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    logic [37:0] exp_q[$];
    int m_idx, m_cnt, m_pp;

    always #2 clk = ~clk;

    can_rxbuf_packer dut (
        .clk(clk), .rst_n(rst_n), .cfg_buf_size(cfg_buf_size), .cfg_buf_count(cfg_buf_count),
        .buf_trig(buf_trig), .rd_req(rd_req), .rd_buf_sel(rd_buf_sel), .rd_offset(rd_offset),
        .rd_data(rd_data), .out_valid(out_valid), .out_data(out_data), .out_bmask(out_bmask),
        .out_sop(out_sop), .out_eop(out_eop), .stat_buf_idx(stat_buf_idx),
        .stat_next_off(stat_next_off), .stat_pingpong(stat_pingpong)
    );

    // Byte value stored at a given offset of a given ping-pong buffer.
    function automatic logic [7:0] mem_byte(input int sel, input int off);
        return 8'((sel * 128 + off * 3 + 17) & 255);
    endfunction

    // Message memory model, one-cycle latency.
    always @(posedge clk) begin
        if (rd_req) begin
            for (int b = 0; b < 4; b++)
                rd_data[8*b +: 8] <= mem_byte(int'(rd_buf_sel), int'(rd_offset) + b);
        end
    end

    function automatic int eff_size(input int s);
        if (s < 16) return 16;
        if (s > 72) return 72;
        return s;
    endfunction

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    // Push the expected words of one buffer and advance the model.
    task automatic model_buf();
        int s, start, n;
        bit first, last;
        logic [31:0] d;
        logic [3:0]  m;
        s = eff_size(int'(cfg_buf_size));
        first = (m_idx == 0);
        if (first) m_cnt = (cfg_buf_count == 0) ? 1 : int'(cfg_buf_count);
        last  = (m_idx == m_cnt - 1);
        start = first ? 0 : 8;
        for (int off = start; off < s; off += 4) begin
            n = (s - off < 4) ? s - off : 4;
            d = '0; m = '0;
            for (int b = 0; b < n; b++) begin
                d[8*b +: 8] = mem_byte(m_pp, off + b);
                m[b] = 1'b1;
            end
            exp_q.push_back({d, m, (first && off == 0), (last && off + 4 >= s)});
        end
        m_idx = last ? 0 : m_idx + 1;
        m_pp  = 1 - m_pp;
    endtask

    // Output monitor; compares every word with the model.
    always @(negedge clk) begin
        if (rst_n && out_valid && !done) begin
            if (exp_q.size() == 0) begin
                chk("R11 unexpected output word", 64'(out_data), 64'hDEAD);
            end else begin
                chk("R3/R4/R5/R7/R8 output word",
                    64'({out_data, out_bmask, out_sop, out_eop}), 64'(exp_q.pop_front()));
            end
        end
    end

    // Watchdog: counts as a failed check and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            fails++; checks++;
            $display("FAIL watchdog got=%0d exp=<150000", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        buf_trig = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_q.delete();
        m_idx = 0; m_cnt = 1; m_pp = 0;
    endtask

    task automatic trig(input int gap);
        @(negedge clk);
        buf_trig = 1'b1;
        model_buf();
        @(negedge clk);
        buf_trig = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic drain(input string tag);
        int w = 0;
        while (exp_q.size() != 0 && w < 3000) begin
            @(negedge clk);
            w++;
        end
        repeat (6) @(negedge clk);
        chk(tag, 64'(exp_q.size()), 64'd0);
    endtask

    initial begin
        int seed, ntr;
        seed = 32'h5EED;
        void'($urandom(seed));
        do_reset();
        // R10: reset state.
        chk("R10 rd_req", 64'(rd_req), 0);
        chk("R10 out_valid", 64'(out_valid), 0);
        chk("R10 stat idx", 64'(stat_buf_idx), 0);
        chk("R10 stat off", 64'(stat_next_off), 0);
        chk("R10 stat pingpong", 64'(stat_pingpong), 0);

        // Basic: 24-byte buffers, one per packet (R3, R5).
        cfg_buf_size = 24; cfg_buf_count = 1;
        trig(0);
        drain("R3 single-buffer packet drained");

        // R1 small size clamped; R4 header skip on second buffer.
        do_reset();
        cfg_buf_size = 5; cfg_buf_count = 2;
        trig(2); trig(0);
        drain("R1 R4 clamp-low two-buffer packet drained");

        // R2 large size clamped; R11 back-to-back triggers queued.
        do_reset();
        cfg_buf_size = 200; cfg_buf_count = 3;
        trig(0); trig(0); trig(0);
        drain("R2 R11 clamp-high burst drained");

        // R6 count zero; R7 trimmed last word (18 bytes).
        do_reset();
        cfg_buf_size = 18; cfg_buf_count = 0;
        trig(0); trig(0);
        drain("R6 R7 count-zero trimmed words drained");

        // R9 / R8 status after partial packet.
        do_reset();
        cfg_buf_size = 40; cfg_buf_count = 3;
        trig(0); trig(0);
        drain("R9 partial packet drained");
        chk("R9 idle index", 64'(stat_buf_idx), 2);
        chk("R9 idle next offset", 64'(stat_next_off), 8);
        chk("R8 pingpong after two buffers", 64'(stat_pingpong), 0);
        trig(0);
        drain("R9 packet closed drained");
        chk("R9 index wraps", 64'(stat_buf_idx), 0);
        chk("R9 offset back to 0", 64'(stat_next_off), 0);
        chk("R8 pingpong after three buffers", 64'(stat_pingpong), 1);

        // Random configurations and trigger bursts.
        for (int it = 0; it < 30; it++) begin
            do_reset();
            cfg_buf_size  = SIZE_W'($urandom_range(0, 99));
            cfg_buf_count = CNT_W'($urandom_range(0, 4));
            ntr = $urandom_range(1, 6);
            for (int k = 0; k < ntr; k++) trig($urandom_range(0, 3));
            drain("R11 random burst drained");
            chk("R8 random pingpong", 64'(stat_pingpong), 64'(ntr % 2));
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule